// File: doc/BRIEF.md
# Shared Staging-Byte Bridge for Wide Registers

This block lets an 8-bit bus reach a bank of internal registers that are wider than one byte. Examples are a free-running counter, a capture value and compare values. Each wide register occupies two byte addresses:

- An even address reaches the low byte.
- The odd address above it reaches the high part.

The bank does not keep one holding byte per register. It keeps a single staging byte, which every register shares.

To write a register atomically, software first writes the high part, which only fills the staging byte. It then writes the low byte, which loads the whole register in one clock from the staging byte and the new low byte. To read a register atomically, software first reads the low byte, which copies the register's high part into the staging byte at that same edge. It then reads the high part back from the staging byte. If the two accesses come in the wrong order, or accesses to different registers are interleaved, a stale or foreign high part is used. That outcome is the intended behaviour, not a fault.

Each bus cycle is classified into one of five access kinds:

| Access kind | Condition | Effect |
|---|---|---|
| `ACC_NONE` | no strobe | nothing changes |
| `ACC_WR_HI` | write strobe, odd address | loads the staging byte |
| `ACC_WR_LO` | write strobe, even address | commits the wide register |
| `ACC_RD_HI` | read strobe, odd address | returns the staging byte |
| `ACC_RD_LO` | read strobe, even address | returns the low byte and captures the high part |

If both strobes are active in the same cycle, the write wins. The kind selects the next value of the staging byte and the read data. Register 0 is the counter: it advances on a count-enable input. The width is a parameter and may be anywhere from 9 to 16 bits. With a width of 10, only the low 2 bits of the staging byte carry data.

Top module: `wide_byte_bridge`

## Requirements
- R1: After reset the staging byte and every wide register are zero.
- R2: A write to an odd (high-part) address stores the data only in the staging byte and leaves every wide register unchanged. The register index is the address shifted right by one.
- R3: A write to an even (low-byte) address loads the addressed register on that clock edge with the staging byte as upper bits and the written byte as the low 8 bits.
- R4: A read of an even address returns the register's live low byte in that cycle, and at the same edge copies the register's upper W-8 bits into the staging byte.
- R5: A read of an odd address returns the staging byte, not the register's live upper bits.
- R6: The staging byte is shared. A low-byte write to one register uses a high part that was staged by an access to another register, and the staging byte keeps its value after a commit.
- R7: Writing the low byte before the high part commits whatever stale value the staging byte holds, and the later high-part write leaves the target register unchanged.
- R8: Register 0 increments by one, wrapping at its width, on each cycle with the count-enable high. A low-byte bus write to register 0 in the same cycle takes priority over the increment.
- R9: With a width of 10, a high-part write keeps only its 2 low data bits, and a high-part read returns those 2 bits with the upper 6 bits reading as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | $clog2(NREG)+1 | Byte address; bit 0 selects the high part |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cnt_inc | input | 1 | Count enable for register 0 |
| reg_values | output | NREG*W | All wide register values, register i in bits [i*W +: W] |

## Verification
The hardest situation to reach from the ports is a commit that combines a high part staged for one register, or a snapshot left behind by a read of another, with a low byte aimed at a different register. The stimulus creates this on purpose: it stages a high part, commits it to one register, and then commits to a second register without staging again. It also reads a low byte from one register and then reads the high part through another register's address. Another hard case is the bus write and the counter step landing on the same edge. To produce it, the count enable is held high across a low-byte write to register 0, and the counter is checked on the following cycles.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WR_HI,
        ACC_WR_LO,
        ACC_RD_HI,
        ACC_RD_LO
    } acc_e;

endpackage

// File: rtl/wbb_decode.sv
module wbb_decode
    import wbb_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = 2,
    parameter int AW    = IDX_W + 1
) (
    input  logic             wr,
    input  logic             rd,
    input  logic [AW-1:0]    addr,
    output acc_e             acc,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);

    always_comb begin
        idx = addr[AW-1:1];
        hit = (int'(idx) < NREG);
        if (wr)
            acc = addr[0] ? ACC_WR_HI : ACC_WR_LO;
        else if (rd)
            acc = addr[0] ? ACC_RD_HI : ACC_RD_LO;
        else
            acc = ACC_NONE;
    end

endmodule

// File: rtl/wbb_stage.sv
module wbb_stage
    import wbb_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_e            acc,
    input  logic            hit,
    input  logic [7:0]      wdata,
    input  logic [HI_W-1:0] snap_val,
    output logic [HI_W-1:0] stage
);

    logic [HI_W-1:0] stage_nxt;

    always_comb begin
        stage_nxt = stage;
        unique case (acc)
            ACC_WR_HI: stage_nxt = wdata[HI_W-1:0];
            ACC_RD_LO: if (hit) stage_nxt = snap_val;
            ACC_NONE, ACC_WR_LO, ACC_RD_HI: stage_nxt = stage;
            default:   stage_nxt = stage;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= stage_nxt;
    end

endmodule

// File: rtl/wbb_bank.sv
module wbb_bank #(
    parameter int NREG  = 4,
    parameter int W     = 16,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [W-1:0]      new_val,
    input  logic              cnt_inc,
    output logic [NREG*W-1:0] flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        logic         sel;
        assign sel = commit && (int'(idx) == i);
        if (i == 0) begin : g_cnt
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (sel)     q <= new_val;
                else if (cnt_inc) q <= q + 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (sel) q <= new_val;
            end
        end
        assign flat[i*W +: W] = q;
    end

endmodule

// File: rtl/wide_byte_bridge.sv
module wide_byte_bridge
    import wbb_pkg::*;
#(
    parameter int NREG = 4,
    parameter int W    = 16,
    parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    parameter int AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_inc,
    output logic [NREG*W-1:0] reg_values
);

    localparam int HI_W = W - 8;

    acc_e             acc;
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic [HI_W-1:0]  stage;
    logic [W-1:0]     live [NREG];
    logic [W-1:0]     sel_val;

    wbb_decode #(.NREG(NREG), .IDX_W(IDX_W), .AW(AW)) u_dec (
        .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .acc(acc), .idx(idx), .hit(hit)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_unpack
        assign live[i] = reg_values[i*W +: W];
    end

    assign sel_val = hit ? live[idx] : '0;

    wbb_stage #(.HI_W(HI_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .acc(acc), .hit(hit),
        .wdata(bus_wdata), .snap_val(sel_val[W-1:8]), .stage(stage)
    );

    wbb_bank #(.NREG(NREG), .W(W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit(acc == ACC_WR_LO && hit), .idx(idx),
        .new_val({stage, bus_wdata}), .cnt_inc(cnt_inc),
        .flat(reg_values)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (acc)
            ACC_RD_LO: bus_rdata = sel_val[7:0];
            ACC_RD_HI: bus_rdata[HI_W-1:0] = stage;
            ACC_NONE, ACC_WR_HI, ACC_WR_LO: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: a staging write alone moves no wide register
    a_r2_hi_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0] && !cnt_inc) |=> $stable(reg_values));

    // R3: low-byte write commits staging byte plus data in one edge
    a_r3_low_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0] && hit) |=>
        (live[$past(idx)] == {$past(stage), $past(bus_wdata)}));

    // R4: low-byte read captures the live upper bits
    a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr[0] && hit) |=>
        (stage == $past(sel_val[W-1:8])));

    // R5: high read right after a staging write returns the staged data
    a_r5_hi_read_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) ##1 (bus_rd && !bus_wr && bus_addr[0]) |->
        (bus_rdata[HI_W-1:0] == $past(bus_wdata[HI_W-1:0])));

    // R8: counter steps by one unless a bus commit targets it
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !(bus_wr && !bus_addr[0] && hit && idx == '0)) |=>
        (live[0] == $past(live[0]) + 1'b1));

    if (HI_W < 8) begin : g_pad_chk
        // R9: unused staging bits read as zero
        a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && bus_addr[0]) |-> (bus_rdata[7:HI_W] == '0));
    end

endmodule

// File: tb/wide_byte_bridge_test.sv
module wide_byte_bridge_test;

    localparam int CLK_P = 10;
    localparam int NREG  = 4;
    localparam int AW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wr = 1'b0, rd = 1'b0, cnt_inc = 1'b0, dev = 1'b0;
    logic [7:0] rdata16, rdata10;
    logic [NREG*16-1:0] vals16;
    logic [NREG*10-1:0] vals10;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    wide_byte_bridge #(.NREG(NREG), .W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr && !dev), .bus_rd(rd && !dev), .bus_rdata(rdata16),
        .cnt_inc(cnt_inc && !dev), .reg_values(vals16)
    );

    wide_byte_bridge #(.NREG(NREG), .W(10)) uut10 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr && dev), .bus_rd(rd && dev), .bus_rdata(rdata10),
        .cnt_inc(1'b0), .reg_values(vals10)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: pops expected read data while a read is presented
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rd && !wr && exp_q.size() > 0) begin
            check(tag_q.pop_front(), dev ? rdata10 : rdata16, exp_q.pop_front());
        end
    end

    task automatic wr_b(input int r, input bit hi, input logic [7:0] d);
        @(negedge clk);
        addr = AW'(r * 2 + int'(hi)); wdata = d; wr = 1'b1; rd = 1'b0;
    endtask

    task automatic rd_b(input int r, input bit hi, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = AW'(r * 2 + int'(hi)); wr = 1'b0; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [15:0] r16(input int i);
        return vals16[i*16 +: 16];
    endfunction

    function automatic logic [15:0] r10(input int i);
        return {6'b0, vals10[i*10 +: 10]};
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R1 regs zero", vals16[15:0] | vals16[31:16] | vals16[47:32] | vals16[63:48], 16'h0);
        check("R1 regs10 zero", {6'b0, vals10[9:0] | vals10[39:30]}, 16'h0);
        rd_b(0, 1, 8'h00, "R1 stage zero");
        // R2: staging only
        wr_b(1, 1, 8'hAB);
        idle();
        check("R2 reg1 unchanged", r16(1), 16'h0000);
        check("R2 reg0 unchanged", r16(0), 16'h0000);
        rd_b(2, 1, 8'hAB, "R5 R6 stage via reg2 addr");
        // R3 commit
        wr_b(1, 0, 8'hCD);
        idle();
        check("R3 reg1 commit", r16(1), 16'hABCD);
        // R6 shared stage reused by another register
        wr_b(2, 0, 8'h11);
        idle();
        check("R6 reg2 uses shared stage", r16(2), 16'hAB11);
        wr_b(3, 1, 8'h77);
        wr_b(3, 0, 8'h88);
        idle();
        check("R3 reg3 commit", r16(3), 16'h7788);
        // R4 snapshot, R5 stage not live
        rd_b(1, 0, 8'hCD, "R4 low read data");
        rd_b(3, 1, 8'hAB, "R5 high read returns snapshot not live");
        // R7 reversed order
        wr_b(2, 0, 8'h22);
        wr_b(2, 1, 8'h99);
        idle();
        check("R7 stale stage committed", r16(2), 16'hAB22);
        rd_b(2, 1, 8'h99, "R7 late high write only staged");
        idle();
        check("R7 target unchanged", r16(2), 16'hAB22);
        // R8 counter
        @(negedge clk); cnt_inc = 1'b1;
        repeat (3) @(negedge clk);
        cnt_inc = 1'b0;
        check("R8 count 3", r16(0), 16'h0003);
        wr_b(0, 1, 8'h12);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h34; wr = 1'b1; cnt_inc = 1'b1;
        idle();
        check("R8 bus write wins", r16(0), 16'h1234);
        @(negedge clk);
        check("R8 count resumes", r16(0), 16'h1235);
        cnt_inc = 1'b0;
        wr_b(0, 1, 8'hFF);
        wr_b(0, 0, 8'hFF);
        idle();
        check("R8 load max", r16(0), 16'hFFFF);
        cnt_inc = 1'b1;
        @(negedge clk);
        cnt_inc = 1'b0;
        check("R8 wrap", r16(0), 16'h0000);
        // R9 10-bit variant
        @(negedge clk); dev = 1'b1;
        wr_b(1, 1, 8'hFF);
        rd_b(1, 1, 8'h03, "R9 pad bits zero");
        wr_b(1, 0, 8'h5A);
        idle();
        check("R9 reg1 10-bit commit", r10(1), 16'h035A);
        wr_b(2, 1, 8'h02);
        wr_b(2, 0, 8'hC3);
        idle();
        check("R9 reg2 10-bit commit", r10(2), 16'h02C3);
        rd_b(1, 0, 8'h5A, "R9 low read");
        rd_b(1, 1, 8'h03, "R9 snapshot high");
        idle();
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule